// File: doc/BRIEF.md
# Four-Channel Edge Timestamp Capture Unit

The block watches four input pins and, when a programmed transition appears on one of them, records the current count of a free-running 16-bit timer into a small queue for that pin. Two timer count buses come in from outside. Channels 0 and 1 share one selector that picks which bus they sample, and channels 2 and 3 share a second selector. Each pin passes through a two-flop synchronizer before the edge detector. Each channel's edge detector can be set to ignore the pin, or to react to rising, falling or both transitions.

Each channel holds up to two timestamps in a queue that keeps the oldest first. Software reads the oldest entry through one data address per channel, and each such read removes that entry. A packed status byte shows how full every queue is, including an overflow code for the case where a third event pushed out the oldest value. A capture sets a per-channel event flag. The flag stays set until software writes a one to clear it. The single interrupt output is raised while any flag is set whose enable bit is also set.

Each queue is a small state machine with four states. EMPTY goes to ONE on a capture. ONE goes to TWO on a capture, to EMPTY on a read, and stays in ONE on a read and capture together. TWO goes to OVER on a capture, to ONE on a read, and stays in TWO on both. OVER stays in OVER on a capture, goes to ONE on a read, and goes to TWO on both. Every capture out of TWO or OVER shifts the queue so that the newest value is kept.

Top module: `tscap_unit`

## Requirements
- R1: After reset, the control register, all flags and all queues are clear. Every register address reads 0 and `irq` is low.
- R2: Control bits [2i+1:2i] set the edge mode of channel i: 00 = none, 01 = rising, 10 = falling, 11 = both edges. A capture happens only for a transition of the selected kind.
- R3: A pin change that is stable before clock edge k is captured at edge k+2. The stored value is the timer count present at that edge, and the queue state and flag change at the same edge.
- R4: Control bit 8 selects the timer for channels 0 and 1, and bit 9 selects it for channels 2 and 3, with 0 = `tmr_a` and 1 = `tmr_b`.
- R5: The status register (address 1) reads channel i's queue state at bits [2i+9:2i+8]: 00 = empty, 01 = one entry, 10 = two entries, 11 = overflow. Bits [7:0] read 0.
- R6: Address 4+i reads the oldest entry of channel i, and a read strobe there removes it. Reading an empty queue returns 0 and changes nothing.
- R7: A capture into a queue in state 10 or 11 drops the oldest entry, appends the new value and sets state 11. A read from 11 leaves state 01, holding the newest value.
- R8: When a read and a capture reach the same queue in the same cycle, the read removes its entry first and the capture is then appended.
- R9: A capture sets flag i. Writing 1 to bit i at address 1 clears the flag, and writing 0 leaves it alone. A capture in the same cycle as a clear leaves the flag set.
- R10: Control bits [15:12] are the enables for channels 0 to 3. `irq` is the OR over all channels of flag AND enable.
- R11: The control register (address 0) reads back what was written, except that bits [11:10] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_in | input | 4 | Raw capture pins, bit i for channel i |
| tmr_a | input | 16 | First timer count bus |
| tmr_b | input | 16 | Second timer count bus |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; removes a queue entry at a data address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 16-bit data, four channels, two synchronizer stages and a 3-bit address. With four channels the two selector groups each cover two channels, so every code of both selectors can be tried. The 16-bit width lets the two timer buses carry distinct values that show which bus was sampled. The two-stage synchronizer places the capture at the third clock edge, which the bench checks cycle by cycle. The two-entry queue reaches overflow after three events, and the bench also lines up a read, or a flag clear, with the exact capture edge.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

    // Queue fill state of one channel; the code is visible in the status register.
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'b00,
        FILL_ONE   = 2'b01,
        FILL_TWO   = 2'b10,
        FILL_OVER  = 2'b11
    } fill_e;

    // Edge mode of one channel, two control bits each.
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

endpackage

// File: rtl/cap_edge_det.sv
`timescale 1ns/1ps
module cap_edge_det
    import cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin,
    input  edge_e mode,
    output logic  hit
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= cur;
        end
    end

    always_comb begin
        unique case (mode)
            EDGE_OFF:  hit = 1'b0;
            EDGE_RISE: hit = cur & ~prev_q;
            EDGE_FALL: hit = ~cur & prev_q;
            EDGE_BOTH: hit = cur ^ prev_q;
            default:   hit = 1'b0;
        endcase
    end

    // A detected event reflects the pin level seen SYNC_STAGES edges earlier.
    assert_sync_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cur == $past(pin, SYNC_STAGES)));

    // A disabled channel never reports an event.
    assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_OFF) |-> !hit);

endmodule

// File: rtl/cap_fifo2.sv
`timescale 1ns/1ps
module cap_fifo2
    import cap_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output fill_e         fill
);

    fill_e         state_q, state_d;
    logic [DW-1:0] e0_q, e0_d;
    logic [DW-1:0] e1_q, e1_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            e0_q    <= '0;
            e1_q    <= '0;
        end else begin
            state_q <= state_d;
            e0_q    <= e0_d;
            e1_q    <= e1_d;
        end
    end

    // Next state and entry contents; a read is applied before a capture.
    always_comb begin
        state_d = state_q;
        e0_d    = e0_q;
        e1_d    = e1_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (push) begin
                    state_d = FILL_ONE;
                    e0_d    = din;
                end
            end
            FILL_ONE: begin
                unique case ({pop, push})
                    2'b11: e0_d = din;
                    2'b10: state_d = FILL_EMPTY;
                    2'b01: begin
                        state_d = FILL_TWO;
                        e1_d    = din;
                    end
                    default: ;
                endcase
            end
            FILL_TWO, FILL_OVER: begin
                unique case ({pop, push})
                    2'b11: begin
                        state_d = FILL_TWO;
                        e0_d    = e1_q;
                        e1_d    = din;
                    end
                    2'b10: begin
                        state_d = FILL_ONE;
                        e0_d    = e1_q;
                    end
                    2'b01: begin
                        state_d = FILL_OVER;
                        e0_d    = e1_q;
                        e1_d    = din;
                    end
                    default: ;
                endcase
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    // Outputs.
    always_comb begin
        fill = state_q;
        head = (state_q == FILL_EMPTY) ? '0 : e0_q;
    end

    assert_over_from_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FILL_OVER) |->
            ($past(state_q) == FILL_TWO || $past(state_q) == FILL_OVER));

    assert_push_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (state_q != FILL_EMPTY));

    assert_empty_pop_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FILL_EMPTY && pop && !push) |=> (state_q == FILL_EMPTY));

    assert_pop_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FILL_ONE && pop && push) |=>
            (state_q == FILL_ONE && head == $past(din)));

endmodule

// File: rtl/tscap_unit.sv
`timescale 1ns/1ps
module tscap_unit
    import cap_pkg::*;
#(
    parameter int DW          = 16,
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cap_in,
    input  logic [DW-1:0]  tmr_a,
    input  logic [DW-1:0]  tmr_b,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           irq
);

    localparam int NGRP     = NCH / 2;
    localparam int SEL_LSB  = 2 * NCH;
    localparam int EN_LSB   = DW - NCH;
    localparam int STAT_LOW = DW - 2 * NCH;

    localparam logic [AW-1:0] ADDR_CTRL = '0;
    localparam logic [AW-1:0] ADDR_STAT = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] DATA_BASE = {1'b1, {(AW-1){1'b0}}};

    localparam logic [DW-1:0] EDGE_MASK = {{(DW-2*NCH){1'b0}}, {(2*NCH){1'b1}}};
    localparam logic [DW-1:0] SEL_MASK  =
        {{(DW-SEL_LSB-NGRP){1'b0}}, {NGRP{1'b1}}, {SEL_LSB{1'b0}}};
    localparam logic [DW-1:0] EN_MASK   = {{NCH{1'b1}}, {EN_LSB{1'b0}}};
    localparam logic [DW-1:0] CTRL_MASK = EDGE_MASK | SEL_MASK | EN_MASK;

    logic [DW-1:0]    ctrl_q;
    logic [NCH-1:0]   flag_q;
    logic [NCH-1:0]   hit;
    logic [NCH-1:0]   pop;
    logic [NCH-1:0]   clr;
    logic [2*NCH-1:0] fill_bits;
    logic [DW-1:0]    head [NCH];

    // Control register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_wr && bus_addr == ADDR_CTRL)
            ctrl_q <= bus_wdata & CTRL_MASK;
    end

    assign clr = (bus_wr && bus_addr == ADDR_STAT) ? bus_wdata[NCH-1:0] : '0;

    // Event flags: a capture wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= hit | (flag_q & ~clr);
    end

    assign irq = |(flag_q & ctrl_q[EN_LSB +: NCH]);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic          grp_sel;
            logic [DW-1:0] stamp;
            fill_e         fill_c;

            assign grp_sel = ctrl_q[SEL_LSB + c/2];
            assign stamp   = grp_sel ? tmr_b : tmr_a;
            assign pop[c]  = bus_rd && (bus_addr == DATA_BASE + AW'(c));

            cap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (cap_in[c]),
                .mode  (edge_e'(ctrl_q[2*c +: 2])),
                .hit   (hit[c])
            );

            cap_fifo2 #(.DW(DW)) u_q (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (hit[c]),
                .din   (stamp),
                .pop   (pop[c]),
                .head  (head[c]),
                .fill  (fill_c)
            );

            assign fill_bits[2*c +: 2] = fill_c;

            assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
                hit[c] |=> flag_q[c]);

            assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[c] && !hit[c]) |=> !flag_q[c]);

            assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q[c]) |-> $past(hit[c]));
        end
    endgenerate

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL)
            bus_rdata = ctrl_q;
        else if (bus_addr == ADDR_STAT)
            bus_rdata = {fill_bits, {STAT_LOW{1'b0}}};
        for (int i = 0; i < NCH; i++)
            if (bus_addr == DATA_BASE + AW'(i))
                bus_rdata = head[i];
    end

    assert_ctrl_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == '0);

endmodule

// File: tb/sim_tscap_unit.sv
`timescale 1ns/1ps
module sim_tscap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cap_in = '0;
    logic [15:0] tmr_a = '0;
    logic [15:0] tmr_b = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tscap_unit u0 (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic        sel;
        logic [1:0]  code;
        logic        from_lvl;
        logic        to_lvl;
        logic [15:0] ta;
        logic [15:0] tb;
        logic        exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 2'b01, 1'b0, 1'b1, 16'h1111, 16'h2222, 1'b1},
        '{2'd0, 1'b1, 2'b01, 1'b0, 1'b1, 16'h1313, 16'h2424, 1'b1},
        '{2'd1, 1'b0, 2'b10, 1'b1, 1'b0, 16'h3535, 16'h4646, 1'b1},
        '{2'd1, 1'b0, 2'b10, 1'b0, 1'b1, 16'h5757, 16'h6868, 1'b0},
        '{2'd2, 1'b1, 2'b11, 1'b0, 1'b1, 16'h7979, 16'h8A8A, 1'b1},
        '{2'd2, 1'b1, 2'b11, 1'b1, 1'b0, 16'h9B9B, 16'hACAC, 1'b1},
        '{2'd3, 1'b0, 2'b00, 1'b0, 1'b1, 16'hBDBD, 16'hCECE, 1'b0},
        '{2'd3, 1'b1, 2'b01, 1'b1, 1'b0, 16'hDFDF, 16'hE0E0, 1'b0},
        '{2'd3, 1'b1, 2'b01, 1'b0, 1'b1, 16'h0F1E, 16'h2D3C, 1'b1},
        '{2'd1, 1'b1, 2'b00, 1'b1, 1'b0, 16'h4B5A, 16'h6978, 1'b0},
        '{2'd2, 1'b0, 2'b10, 1'b1, 1'b0, 16'h8796, 16'hA5B4, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b0;
        #1 v = bus_rdata;
    endtask

    function automatic logic [15:0] fld(input logic [15:0] st, input int ch);
        return {14'd0, st[8 + 2*ch +: 2]};
    endfunction

    task automatic pulse(input int ch, input logic [15:0] val);
        tmr_a = val; tmr_b = val;
        cap_in[ch] = 1'b1;
        ticks(4);
        cap_in[ch] = 1'b0;
        ticks(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] c;
        ticks(3);
        rst_n = 1'b1;
        ticks(1);

        // R1 reset state
        peek(3'd0, v); chk("R1 ctrl", v, 16'h0000);
        peek(3'd1, v); chk("R1 status", v, 16'h0000);
        peek(3'd4, v); chk("R1 data0", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        // R11 control readback masks reserved bits
        wr(3'd0, 16'hFFFF);
        peek(3'd0, v); chk("R11 ctrl readback", v, 16'hF3FF);
        wr(3'd0, 16'h0000);

        // Table of single-event vectors
        for (int k = 0; k < NV; k++) begin
            vec_t t;
            t = VECS[k];
            wr(3'd0, 16'h0000);
            cap_in[t.ch] = t.from_lvl;
            ticks(4);
            c = (16'(t.code) << (2*t.ch)) | (16'(t.sel) << (8 + t.ch/2))
                | (16'h1 << (12 + t.ch));
            wr(3'd0, c);
            tmr_a = t.ta; tmr_b = t.tb;
            cap_in[t.ch] = t.to_lvl;
            ticks(4);
            peek(3'd1, v);
            chk("R5 fill after vector", fld(v, t.ch), t.exp ? 16'd1 : 16'd0);
            chk("R10 irq after vector", {15'd0, irq}, {15'd0, t.exp});
            rd(3'd4 + 3'(t.ch), v);
            chk("R2/R4 captured value", v, t.exp ? (t.sel ? t.tb : t.ta) : 16'h0000);
            wr(3'd1, 16'h000F);
        end

        // R3 capture timing
        wr(3'd0, 16'h0000);
        cap_in = 4'b0000;
        ticks(4);
        wr(3'd1, 16'h000F);
        wr(3'd0, 16'h1001);
        tmr_a = 16'h0100; cap_in[0] = 1'b1;
        @(negedge clk); tmr_a = 16'h0200;
        @(negedge clk); tmr_a = 16'h0300;
        peek(3'd1, v); chk("R3 not yet captured", fld(v, 0), 16'd0);
        chk("R3 irq not yet", {15'd0, irq}, 16'd0);
        @(negedge clk);
        peek(3'd1, v); chk("R3 captured at third edge", fld(v, 0), 16'd1);
        chk("R3 irq at third edge", {15'd0, irq}, 16'd1);
        rd(3'd4, v); chk("R3 timer at third edge", v, 16'h0300);
        wr(3'd1, 16'h000F);

        // R7 overflow on channel 1
        wr(3'd0, 16'h2004);
        pulse(1, 16'h0011);
        pulse(1, 16'h0022);
        peek(3'd1, v); chk("R5 two entries", fld(v, 1), 16'd2);
        pulse(1, 16'h0033);
        peek(3'd1, v); chk("R7 overflow state", fld(v, 1), 16'd3);
        rd(3'd5, v); chk("R7 oldest dropped", v, 16'h0022);
        peek(3'd1, v); chk("R7 after pop from overflow", fld(v, 1), 16'd1);
        rd(3'd5, v); chk("R6 second entry", v, 16'h0033);
        peek(3'd1, v); chk("R6 drained", fld(v, 1), 16'd0);
        rd(3'd5, v); chk("R6 empty read", v, 16'h0000);
        peek(3'd1, v); chk("R6 empty pop no effect", fld(v, 1), 16'd0);
        peek(3'd1, v); chk("R5 low byte zero", v & 16'h00FF, 16'h0000);

        // R8 read and capture in the same cycle on channel 2
        wr(3'd1, 16'h000F);
        wr(3'd0, 16'h4010);
        pulse(2, 16'h0044);
        tmr_a = 16'h0055; cap_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(3'd6, v); chk("R8 old head read", v, 16'h0044);
        peek(3'd1, v); chk("R8 one entry remains", fld(v, 2), 16'd1);
        peek(3'd6, v); chk("R8 new head", v, 16'h0055);
        cap_in[2] = 1'b0;
        ticks(4);
        rd(3'd6, v);

        // R9 flag clearing
        chk("R9 flag set by capture", {15'd0, irq}, 16'd1);
        wr(3'd1, 16'h0000);
        chk("R9 write zero keeps flag", {15'd0, irq}, 16'd1);
        wr(3'd1, 16'h0004);
        chk("R9 write one clears", {15'd0, irq}, 16'd0);
        tmr_a = 16'h0066; cap_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(3'd1, 16'h0004);
        chk("R9 capture beats clear", {15'd0, irq}, 16'd1);
        cap_in[2] = 1'b0;
        ticks(4);
        wr(3'd1, 16'h000F);
        rd(3'd6, v);

        // R10 enable masks the interrupt but not the flag
        wr(3'd0, 16'h0040);
        pulse(3, 16'h0077);
        chk("R10 masked irq", {15'd0, irq}, 16'd0);
        wr(3'd0, 16'h8040);
        chk("R10 unmasked irq", {15'd0, irq}, 16'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule